// File: doc/BRIEF.md
# Microcode Fetch Redirection Unit

This unit sits between a microcode sequencer and its instruction store. It answers every microcode fetch with one triad: three micro-operations plus a sequence word. A small table of match entries pairs a source address in the fixed ROM with a destination slot in a writable patch RAM. When a fetch address equals the source of a valid entry and redirection is globally enabled, the triad comes from the patch RAM at that entry's destination. Otherwise it comes from the ROM. In both cases the timing and the response are identical, so the sequencer cannot tell a patched fetch from a normal one.

Privileged software programs the unit through a single-cycle write port. That port loads patch RAM slots, writes match entries and sets the global enable. The patch RAM and the table are volatile: reset clears every entry and the enable, so fetches fall back to ROM until software programs the unit again. A hook normally uses two consecutive patch slots (entry and exit), so the patch RAM holds twice as many triads as there are match entries.

The fetch side is a valid/ready stream with one register stage. A request is accepted when `req_valid` and `req_ready` are both high. Its response appears on the next cycle. A response that is not taken (`rsp_ready` low) stays on the outputs unchanged, and no new request is accepted until it is taken. Throughput is one fetch per cycle while `rsp_ready` stays high.

Top module: `mfr_unit`

## Requirements
- R1: Reset behaviour.
  - While reset is held and in the first cycle after it, `rsp_valid` is low and `req_ready` is high.
  - Reset invalidates every match entry and clears the global enable.
  - After reset, every fetch returns the ROM triad until the unit is reprogrammed.
- R2: Triad layout and ROM contents.
  - A triad is 56 bits: micro-op 0 in [15:0], micro-op 1 in [31:16], micro-op 2 in [47:32] and the sequence word in [55:48].
  - For ROM address a, micro-op k is the low 16 bits of a*40503 + k*7919 + 17, and the sequence word is the low 8 bits of a*29 + 3.
  - A fetch that does not redirect returns exactly this triad.
- R3: A fetch whose address equals the source of a valid entry, with redirection enabled, returns the patch RAM triad held at that entry's destination slot.
  - Patch RAM is written with `cfg_kind` = 0: `cfg_idx` selects the slot and `cfg_wdata` is the triad.
- R4: Match entry writes.
  - An entry is written with `cfg_kind` = 1 and `cfg_idx` as the entry number.
  - The source address is taken from `cfg_wdata`[15:0] (low `ROM_AW` bits used).
  - The destination slot is taken from `cfg_wdata`[31:16] (low log2(`PRAM_DEPTH`) bits used).
  - The valid flag is `cfg_wdata`[32].
  - A write whose entry number is not below `N_ENTRY` has no effect. Both the 16-entry and the 8-entry build follow this rule.
- R5: When several valid entries share a source address, the entry with the lowest number supplies the destination.
- R6: The global enable is written with `cfg_kind` = 2 and takes its value from `cfg_wdata`[0]. While it is clear, every fetch returns the ROM triad even if entries are valid.
  - `cfg_kind` = 3 has no effect.
- R7: A response becomes valid in the cycle after its request is accepted, whether the fetch hits or misses.
- R8: Back-pressure.
  - While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low.
  - In that state, `rsp_valid` and `rsp_triad` hold their values into the next cycle.
- R9: A configuration write that completes on the same clock edge as a fetch acceptance does not affect that fetch. It affects every fetch accepted on a later edge.
- R10: The patch RAM holds `PRAM_DEPTH` triads (default twice `N_ENTRY`).
  - A patch write whose slot is not below `PRAM_DEPTH` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_kind | input | 2 | Write target: 0 patch slot, 1 match entry, 2 global enable, 3 none |
| cfg_idx | input | CFG_IW | Patch slot or entry number |
| cfg_wdata | input | 56 | Triad for patch writes; packed entry fields or enable bit otherwise |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Unit can accept a fetch this cycle |
| req_addr | input | ROM_AW | Microcode ROM address being fetched |
| rsp_valid | output | 1 | Triad present on `rsp_triad` |
| rsp_ready | input | 1 | Sequencer takes the triad this cycle |
| rsp_triad | output | 56 | Fetched triad |

## Verification
The assertions assume the sequencer keeps `rsp_ready` meaningful whenever `rsp_valid` is high. They also assume that configuration writes are single-cycle pulses that may coincide with fetch acceptance. The stimulus only changes inputs at falling edges. It drives `cfg_we` for exactly one cycle per write. It withdraws or changes a request only after the cycle in which that request was accepted. A deliberate overlap of a write with a fetch checks the edge at which a write takes effect. Redirected triads are only expected after every patch slot that a live entry points at has been loaded.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

  localparam int UOP_W   = 16;
  localparam int SEQ_W   = 8;
  localparam int UOPS    = 3;
  localparam int TRIAD_W = UOPS * UOP_W + SEQ_W;

  // Bit positions of the packed match-entry write word.
  localparam int F_SRC_LO = 0;
  localparam int F_DST_LO = 16;
  localparam int F_VALID  = 32;

  // ROM content generator constants.
  localparam int unsigned ROM_MUL_A  = 40503;
  localparam int unsigned ROM_MUL_K  = 7919;
  localparam int unsigned ROM_BIAS   = 17;
  localparam int unsigned SEQ_MUL    = 29;
  localparam int unsigned SEQ_BIAS   = 3;

  typedef enum logic [1:0] {
    CFG_PATCH  = 2'd0,
    CFG_ENTRY  = 2'd1,
    CFG_ENABLE = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_kind_e;

  typedef logic [TRIAD_W-1:0] triad_t;

  function automatic triad_t rom_triad(input logic [31:0] a);
    triad_t t;
    for (int k = 0; k < UOPS; k++) begin
      t[k*UOP_W +: UOP_W] = UOP_W'(a * ROM_MUL_A + 32'(k) * ROM_MUL_K + ROM_BIAS);
    end
    t[UOPS*UOP_W +: SEQ_W] = SEQ_W'(a * SEQ_MUL + SEQ_BIAS);
    return t;
  endfunction

endpackage

// File: rtl/mfr_rom.sv
module mfr_rom
  import mfr_pkg::*;
#(
  parameter int ROM_AW = 10
)(
  input  logic [ROM_AW-1:0] addr,
  output triad_t            data
);

  // Constant table computed per micro-op lane; each lane is an independent
  // multiply-add on the address so synthesis folds it into ROM logic.
  genvar k;
  generate
    for (k = 0; k < UOPS; k++) begin : g_lane
      assign data[k*UOP_W +: UOP_W] =
        UOP_W'(32'(addr) * ROM_MUL_A + 32'(k) * ROM_MUL_K + ROM_BIAS);
    end
  endgenerate

  assign data[UOPS*UOP_W +: SEQ_W] = SEQ_W'(32'(addr) * SEQ_MUL + SEQ_BIAS);

endmodule

// File: rtl/mfr_match_table.sv
module mfr_match_table #(
  parameter int N_ENTRY = 16,
  parameter int ROM_AW  = 10,
  parameter int PAW     = 5,
  parameter int IW      = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [ROM_AW-1:0]  wr_src,
  input  logic [PAW-1:0]     wr_dst,
  input  logic               wr_valid,
  input  logic [ROM_AW-1:0]  lk_addr,
  output logic               lk_hit,
  output logic [PAW-1:0]     lk_dst,
  output logic [N_ENTRY-1:0] win_vec
);

  logic [N_ENTRY-1:0] ent_v;
  logic [ROM_AW-1:0]  ent_src [N_ENTRY];
  logic [PAW-1:0]     ent_dst [N_ENTRY];
  logic [N_ENTRY-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int e = 0; e < N_ENTRY; e++) begin
        ent_src[e] <= '0;
        ent_dst[e] <= '0;
      end
    end else if (wr_en) begin
      for (int e = 0; e < N_ENTRY; e++) begin
        if (32'(wr_idx) == e) begin
          ent_v[e]   <= wr_valid;
          ent_src[e] <= wr_src;
          ent_dst[e] <= wr_dst;
        end
      end
    end
  end

  // Parallel comparators, one per entry.
  genvar g;
  generate
    for (g = 0; g < N_ENTRY; g++) begin : g_cmp
      assign hit_vec[g] = ent_v[g] && (ent_src[g] == lk_addr);
    end
  endgenerate

  // Lowest-numbered hit wins: isolate the least significant set bit.
  assign win_vec = hit_vec & (~hit_vec + N_ENTRY'(1));
  assign lk_hit  = |hit_vec;

  always_comb begin
    lk_dst = '0;
    for (int e = 0; e < N_ENTRY; e++) begin
      if (win_vec[e]) lk_dst = lk_dst | ent_dst[e];
    end
  end

endmodule

// File: rtl/mfr_patch_ram.sv
module mfr_patch_ram
  import mfr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PAW   = 5,
  parameter int IW    = 8
)(
  input  logic           clk,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  triad_t         wr_data,
  input  logic [PAW-1:0] rd_addr,
  output triad_t         rd_data
);

  triad_t mem [DEPTH];
  logic   in_range;

  assign in_range = (32'(wr_idx) < DEPTH);

  // Volatile storage: contents are not reset.
  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[wr_idx[PAW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mfr_unit.sv
module mfr_unit
  import mfr_pkg::*;
#(
  parameter int N_ENTRY    = 16,
  parameter int ROM_AW     = 10,
  parameter int PRAM_DEPTH = 2 * N_ENTRY,
  parameter int CFG_IW     = 8
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_kind,
  input  logic [CFG_IW-1:0]   cfg_idx,
  input  logic [TRIAD_W-1:0]  cfg_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ROM_AW-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [TRIAD_W-1:0]  rsp_triad
);

  localparam int PAW = (PRAM_DEPTH > 1) ? $clog2(PRAM_DEPTH) : 1;

  cfg_kind_e           kind;
  logic                ent_we, pat_we, en_we;
  logic                redir_en;
  logic                lk_hit;
  logic [PAW-1:0]      lk_dst;
  logic [N_ENTRY-1:0]  win_vec;
  triad_t              rom_data, pram_data, next_triad;
  logic                fetch_go;
  logic                unused_cfg;

  // ---------------- configuration decode ----------------
  assign kind   = cfg_kind_e'(cfg_kind);
  assign ent_we = cfg_we && (kind == CFG_ENTRY);
  assign pat_we = cfg_we && (kind == CFG_PATCH);
  assign en_we  = cfg_we && (kind == CFG_ENABLE);
  assign unused_cfg = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)     redir_en <= 1'b0;
    else if (en_we) redir_en <= cfg_wdata[0];
  end

  // ---------------- storage ----------------
  mfr_match_table #(
    .N_ENTRY (N_ENTRY),
    .ROM_AW  (ROM_AW),
    .PAW     (PAW),
    .IW      (CFG_IW)
  ) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ent_we),
    .wr_idx   (cfg_idx),
    .wr_src   (cfg_wdata[F_SRC_LO +: ROM_AW]),
    .wr_dst   (cfg_wdata[F_DST_LO +: PAW]),
    .wr_valid (cfg_wdata[F_VALID]),
    .lk_addr  (req_addr),
    .lk_hit   (lk_hit),
    .lk_dst   (lk_dst),
    .win_vec  (win_vec)
  );

  mfr_patch_ram #(
    .DEPTH (PRAM_DEPTH),
    .PAW   (PAW),
    .IW    (CFG_IW)
  ) u_pram (
    .clk     (clk),
    .wr_en   (pat_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_addr (lk_dst),
    .rd_data (pram_data)
  );

  mfr_rom #(
    .ROM_AW (ROM_AW)
  ) u_rom (
    .addr (req_addr),
    .data (rom_data)
  );

  // ---------------- fetch stream ----------------
  assign next_triad = (redir_en && lk_hit) ? pram_data : rom_data;
  assign req_ready  = !rsp_valid || rsp_ready;
  assign fetch_go   = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_triad <= '0;
    end else if (fetch_go) begin
      rsp_valid <= 1'b1;
      rsp_triad <= next_triad;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mfr_chk.sv
module mfr_chk
  import mfr_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int ROM_AW  = 10
)(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ROM_AW-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [TRIAD_W-1:0] rsp_triad,
  input logic               redir_en,
  input logic [N_ENTRY-1:0] win_vec
);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_triad))); // R8

  AST_REQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R7

  AST_RSP_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready)); // R7

  AST_ROM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !redir_en) |=>
      (rsp_triad == rom_triad(32'($past(req_addr))))); // R6

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec)); // R5

endmodule

bind mfr_unit mfr_chk #(
  .N_ENTRY (N_ENTRY),
  .ROM_AW  (ROM_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_triad (rsp_triad),
  .redir_en  (redir_en),
  .win_vec   (win_vec)
);

// File: tb/sim_mfr_unit.sv
module sim_mfr_unit;
  import mfr_pkg::*;

  localparam int AW = 10;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_we;
  logic [1:0]         cfg_kind;
  logic [7:0]         cfg_idx;
  logic [TRIAD_W-1:0] cfg_wdata;
  logic               req_valid;
  logic [AW-1:0]      req_addr;
  logic               rsp_ready;
  logic               rdy0, rdy1, rv0, rv1;
  logic [TRIAD_W-1:0] rt0, rt1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  mfr_unit #(.N_ENTRY(16), .ROM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(rdy0), .req_addr(req_addr), .rsp_valid(rv0),
    .rsp_ready(rsp_ready), .rsp_triad(rt0));

  mfr_unit #(.N_ENTRY(8), .ROM_AW(AW)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(rdy1), .req_addr(req_addr), .rsp_valid(rv1),
    .rsp_ready(rsp_ready), .rsp_triad(rt1));

  // ---------------- reference model ----------------
  int               m_src [16];
  int               m_dst [16];
  bit               m_val [16];
  bit               m_en;
  logic [55:0]      pm0 [32];
  logic [55:0]      pm1 [16];

  function automatic logic [55:0] exp_rom(int a);
    logic [15:0] u_a, u_b, u_c;
    logic [7:0]  s;
    u_a = 16'(a * 40503 + 17);
    u_b = 16'(a * 40503 + 7936);
    u_c = 16'(a * 40503 + 15855);
    s   = 8'(a * 29 + 3);
    return {s, u_c, u_b, u_a};
  endfunction

  function automatic logic [55:0] pat(int i);
    return {8'(i * 11 + 5), 16'(i * 4099 + 3), 16'(i * 613 + 77), 16'(i * 97 + 1)};
  endfunction

  function automatic logic [55:0] expect_at(int a, int lim);
    if (m_en) begin
      for (int e = 0; e < lim; e++) begin
        if (m_val[e] && m_src[e] == a) begin
          if (lim == 16) return pm0[m_dst[e] % 32];
          else           return pm1[m_dst[e] % 16];
        end
      end
    end
    return exp_rom(a);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] kind, int idx, logic [55:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_kind  = kind;
    cfg_idx   = 8'(idx);
    cfg_wdata = data;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  function automatic logic [55:0] entry_word(int src, int dst, bit v);
    logic [55:0] w;
    w = '0;
    w[15:0]  = 16'(src);
    w[31:16] = 16'(dst);
    w[32]    = v;
    return w;
  endfunction

  task automatic set_entry(int idx, int src, int dst, bit v);
    cfg_write(2'd1, idx, entry_word(src, dst, v));
    if (idx < 16) begin
      m_src[idx] = src; m_dst[idx] = dst; m_val[idx] = v;
    end
  endtask

  task automatic load_patch(int idx, logic [55:0] d);
    cfg_write(2'd0, idx, d);
    if (idx < 32) pm0[idx] = d;
    if (idx < 16) pm1[idx] = d;
  endtask

  task automatic set_en(bit v);
    cfg_write(2'd2, 0, {55'd0, v});
    m_en = v;
  endtask

  task automatic fetch(int a, string req);
    logic [55:0] e0, e1;
    e0 = expect_at(a, 16);
    e1 = expect_at(a, 8);
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1;
    req_addr  = AW'(a);
    check(rdy0 && rdy1 && !rv0 && !rv1, {req, "/R7 idle before accept"},
          {rdy0, rdy1, rv0, rv1}, 64'b1100);
    @(negedge clk);
    req_valid = 1'b0;
    check(rv0 && rv1, {req, "/R7 valid after one cycle"}, {rv0, rv1}, 64'b11);
    check(rt0 == e0, {req, " u0"}, rt0, e0);
    check(rt1 == e1, {req, " u1"}, rt1, e1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 2'd0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    m_en = 0;
    for (int e = 0; e < 16; e++) begin m_val[e] = 0; m_src[e] = 0; m_dst[e] = 0; end
    repeat (3) @(negedge clk);
    check(!rv0 && !rv1 && rdy0 && rdy1, "R1 in reset", {rv0, rv1, rdy0, rdy1}, 64'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rv0 && !rv1 && rdy0 && rdy1, "R1 after reset", {rv0, rv1, rdy0, rdy1}, 64'b0011);

    // R1/R2: every address from ROM after reset
    for (int a = 0; a < 1024; a++) fetch(a, "R1 R2 rom sweep");

    // R10: load every patch slot (writes above depth ignored in the 8-entry build)
    for (int i = 0; i < 32; i++) load_patch(i, pat(i));
    for (int e = 0; e < 16; e++) set_entry(e, e * 61 + 7, 2 * e, 1'b1);

    // R6: entries valid but enable clear -> ROM
    for (int e = 0; e < 16; e++) fetch(e * 61 + 7, "R6 disabled");
    cfg_write(2'd3, 0, 56'd1);
    for (int e = 0; e < 4; e++) fetch(e * 61 + 7, "R6 kind3 no effect");

    // R3/R4: enabled sweep over all addresses
    set_en(1'b1);
    for (int a = 0; a < 1024; a++) fetch(a, "R3 R4 redirect sweep");

    // R5: duplicate sources, lowest index wins
    set_entry(9, 3 * 61 + 7, 31, 1'b1);
    fetch(3 * 61 + 7, "R5 entry3 over entry9");
    set_entry(3, 3 * 61 + 7, 6, 1'b0);
    fetch(3 * 61 + 7, "R5 R4 entry9 alone");
    set_entry(12, 5 * 61 + 7, 1, 1'b1);
    fetch(5 * 61 + 7, "R5 entry5 over entry12");

    // R4: out-of-range entry number ignored
    set_entry(40, 1000, 0, 1'b1);
    fetch(1000, "R4 idx40 ignored");

    // R10: out-of-range patch slot ignored; destination wraps to slot 1
    load_patch(33, pat(99));
    set_entry(2, 2 * 61 + 7, 33, 1'b1);
    fetch(2 * 61 + 7, "R10 slot33 ignored");
    set_entry(7, 7 * 61 + 7, 18, 1'b1);
    fetch(7 * 61 + 7, "R10 depth per build");

    // R9: write on the same edge as a fetch acceptance
    begin
      logic [55:0] old0, old1;
      old0 = expect_at(500, 16);
      old1 = expect_at(500, 8);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 2'd1; cfg_idx = 8'd6;
      cfg_wdata = entry_word(500, 10, 1'b1);
      req_valid = 1'b1; req_addr = AW'(500); rsp_ready = 1'b1;
      @(posedge clk);
      #1 cfg_we = 1'b0;
      m_src[6] = 500; m_dst[6] = 10; m_val[6] = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rt0 == old0, "R9 same-edge u0", rt0, old0);
      check(rt1 == old1, "R9 same-edge u1", rt1, old1);
    end
    fetch(500, "R9 next fetch");

    // R8: back-pressure
    begin
      logic [55:0] ea0, ea1, eb0, eb1;
      ea0 = expect_at(500, 16); ea1 = expect_at(500, 8);
      eb0 = expect_at(11, 16);  eb1 = expect_at(11, 8);
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_addr = AW'(500);
      @(negedge clk);
      req_addr = AW'(11);
      check(rv0 && rv1 && !rdy0 && !rdy1, "R8 stall", {rv0, rv1, rdy0, rdy1}, 64'b1100);
      repeat (2) @(negedge clk);
      check(rt0 == ea0, "R8 hold u0", rt0, ea0);
      check(rt1 == ea1, "R8 hold u1", rt1, ea1);
      check(!rdy0 && !rdy1, "R8 still stalled", {rdy0, rdy1}, 64'b00);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rv0 && rv1, "R8 R7 second valid", {rv0, rv1}, 64'b11);
      check(rt0 == eb0, "R8 second u0", rt0, eb0);
      check(rt1 == eb1, "R8 second u1", rt1, eb1);
    end

    // R6: clearing enable returns to ROM
    set_en(1'b0);
    fetch(500, "R6 cleared");
    fetch(0 * 61 + 7, "R6 cleared 2");

    // R1: reset clears entries and enable
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_en = 0;
    for (int e = 0; e < 16; e++) m_val[e] = 0;
    set_en(1'b1);
    for (int e = 0; e < 16; e++) fetch(e * 61 + 7, "R1 entries cleared");
    fetch(500, "R1 entries cleared 500");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule